// File: doc/BRIEF.md
# Dual-Modulus Feedback Divider

This block is the feedback divider of an integer-N frequency synthesizer. It runs on the oscillator-rate divider clock and produces one pulse for every N = B·P + A input cycles. The divider is built from three parts. The first is a two-modulus prescaler model that counts either P+1 or P clocks per cycle. The second is a swallow counter (A), which keeps the prescaler at P+1 until it reaches zero. The third is a main counter (B), which sets the length of the whole frame. When B runs out, both counters and the prescaler reload together.

The prescaler modulus comes from a two-bit select: code 0 gives 8/9, code 1 gives 16/17 and code 2 gives 32/33. Code 3 is illegal. A, B and the select are plain inputs. They are sampled only at the reload point, so a frame that is already running always finishes with the settings it started with. An illegal setting raises an error flag and is never loaded; the divider keeps the last accepted setting.

Top module: `dmp_divider`

## Requirements
- R1: While reset is active and right after it ends, `div_pulse`, `mod_ctl` and `cfg_err` are 0. The reset setting is A=0, B=1, select 0 (P=8). The first pulse is high in the 7th cycle after reset is released.
- R2: With a legal setting, consecutive `div_pulse` assertions are exactly B·P + A cycles apart, for P = 8, 16 and 32 (select codes 0, 1, 2).
- R3: In each frame, `mod_ctl` (1 = divide by P+1) is high for exactly A·(P+1) cycles. These are the first cycles of the frame, and `mod_ctl` stays low for the rest of the frame.
- R4: `div_pulse` is high for one cycle only, in the last input cycle of the frame.
- R5: When B equals A, the frame lasts A·(P+1) cycles and `mod_ctl` is high for the entire frame.
- R6: When A is 0, `mod_ctl` stays low and the frame lasts B·P cycles.
- R7: A change of A, B or select in the middle of a frame does not alter that frame's length. The new setting governs the next frame.
- R8: `cfg_err` is 1 one cycle after the inputs present an illegal setting: select 3, A ≥ P, B < A, or B = 0. An illegal setting is not loaded, so the previous frame length continues.
- R9: `cfg_err` returns to 0 one cycle after the inputs become legal again.
- R10: The full 13-bit B range works: B=8191, A=7, P=8 gives 65535 cycles per frame.
- R11: The smallest contiguous ratio P²−P is reached with A=0, B=P−1. At P=32 this is 992 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Divider (oscillator-rate) clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| swallow_in | input | AW (6) | Programmed A value |
| main_in | input | BW (13) | Programmed B value |
| ps_sel | input | 2 | Prescaler select: 0→8/9, 1→16/17, 2→32/33, 3 illegal |
| div_pulse | output | 1 | One-cycle pulse per B·P+A input cycles |
| mod_ctl | output | 1 | 1 while the prescaler divides by P+1 |
| cfg_err | output | 1 | Registered flag for an illegal programmed setting |

## Verification
Each fault in the counter state shows up at the ports within one frame.

- A wrong prescaler reload value moves the next `div_pulse` by one or more cycles.
- A swallow counter that stops at the wrong point changes the number of high `mod_ctl` cycles in that frame.
- A main counter that reloads at the wrong point changes the pulse spacing of the very next frame.

Faults in configuration handling are caught another way. The bench changes inputs in the middle of a frame, and also presents illegal settings. In both cases it expects the old spacing to persist, so any premature or unguarded load shows up as a wrong frame length.

// File: rtl/dmp_pkg.sv
package dmp_pkg;
   localparam int PCW = 6;

   typedef enum logic [1:0] {
      PS_8  = 2'd0,
      PS_16 = 2'd1,
      PS_32 = 2'd2,
      PS_XX = 2'd3
   } ps_sel_e;

   // Base modulus P for a select code; 0 marks the illegal code.
   function automatic logic [PCW-1:0] ps_mod(input logic [1:0] s);
      case (s)
         2'd0:    ps_mod = PCW'(8);
         2'd1:    ps_mod = PCW'(16);
         2'd2:    ps_mod = PCW'(32);
         default: ps_mod = '0;
      endcase
   endfunction
endpackage

// File: rtl/dmp_prescaler.sv
module dmp_prescaler #(
   parameter int             PCW     = 6,
   parameter logic [PCW-1:0] RST_VAL = 7
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [PCW-1:0] rl_val,
   output logic           tc
);
   logic [PCW-1:0] pcnt_q;

   assign tc = (pcnt_q == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  pcnt_q <= RST_VAL;
      else if (tc) pcnt_q <= rl_val;
      else         pcnt_q <= pcnt_q - 1'b1;
   end
endmodule

// File: rtl/dmp_ab_counters.sv
module dmp_ab_counters #(
   parameter int            AW    = 6,
   parameter int            BW    = 13,
   parameter logic [AW-1:0] RST_A = '0,
   parameter logic [BW-1:0] RST_B = 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          pre_tc,
   input  logic          load,
   input  logic [AW-1:0] ld_a,
   input  logic [BW-1:0] ld_b,
   output logic [AW-1:0] a_cnt,
   output logic [AW-1:0] a_dec,
   output logic          b_last
);
   logic [AW-1:0] a_q;
   logic [BW-1:0] b_q;

   assign a_cnt  = a_q;
   assign a_dec  = (a_q != '0) ? a_q - 1'b1 : a_q;
   assign b_last = (b_q == BW'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         a_q <= RST_A;
         b_q <= RST_B;
      end else if (load) begin
         a_q <= ld_a;
         b_q <= ld_b;
      end else if (pre_tc) begin
         a_q <= a_dec;
         b_q <= b_q - 1'b1;
      end
   end
endmodule

// File: rtl/dmp_cfg_guard.sv
module dmp_cfg_guard
   import dmp_pkg::*;
#(
   parameter int            AW      = 6,
   parameter int            BW      = 13,
   parameter logic [AW-1:0] RST_A   = '0,
   parameter logic [BW-1:0] RST_B   = 1,
   parameter logic [1:0]    RST_SEL = 2'd0
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [AW-1:0]  a_in,
   input  logic [BW-1:0]  b_in,
   input  logic [1:0]     sel_in,
   input  logic           take,
   output logic [AW-1:0]  nxt_a,
   output logic [BW-1:0]  nxt_b,
   output logic [PCW-1:0] nxt_p,
   output logic [PCW-1:0] act_p,
   output logic           cfg_err
);
   localparam int CW = (AW > PCW) ? AW : PCW;

   logic [AW-1:0]  act_a_q;
   logic [BW-1:0]  act_b_q;
   logic [1:0]     act_s_q;
   logic           err_q;
   logic [PCW-1:0] p_in;
   logic           bad;

   assign p_in = ps_mod(sel_in);
   assign bad  = (sel_in == PS_XX)
              || (CW'(a_in) >= CW'(p_in))
              || (b_in < BW'(a_in))
              || (b_in == '0);

   assign act_p   = ps_mod(act_s_q);
   assign nxt_a   = bad ? act_a_q : a_in;
   assign nxt_b   = bad ? act_b_q : b_in;
   assign nxt_p   = bad ? act_p   : p_in;
   assign cfg_err = err_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_a_q <= RST_A;
         act_b_q <= RST_B;
         act_s_q <= RST_SEL;
         err_q   <= 1'b0;
      end else begin
         err_q <= bad;
         if (take && !bad) begin
            act_a_q <= a_in;
            act_b_q <= b_in;
            act_s_q <= sel_in;
         end
      end
   end
endmodule

// File: rtl/dmp_divider.sv
module dmp_divider
   import dmp_pkg::*;
#(
   parameter int            AW      = 6,
   parameter int            BW      = 13,
   parameter logic [AW-1:0] RST_A   = '0,
   parameter logic [BW-1:0] RST_B   = 1,
   parameter logic [1:0]    RST_SEL = 2'd0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [AW-1:0] swallow_in,
   input  logic [BW-1:0] main_in,
   input  logic [1:0]    ps_sel,
   output logic          div_pulse,
   output logic          mod_ctl,
   output logic          cfg_err
);
   localparam logic [PCW-1:0] P0     = ps_mod(RST_SEL);
   localparam logic [PCW-1:0] RST_PC = (RST_A != '0) ? P0 : P0 - 1'b1;

   // Elaboration checks on the parameter set
   generate
      if (AW < 5) begin : g_chk_aw
         $error("AW must cover A up to 31");
      end
      if (BW < AW) begin : g_chk_bw
         $error("BW must be at least AW");
      end
      if (RST_SEL == 2'd3 || RST_B == '0 || RST_B < BW'(RST_A)) begin : g_chk_rst
         $error("reset setting must be legal");
      end
   endgenerate

   logic           pre_tc;
   logic           term;
   logic           b_last;
   logic [AW-1:0]  a_cnt;
   logic [AW-1:0]  a_dec;
   logic [AW-1:0]  nxt_a;
   logic [BW-1:0]  nxt_b;
   logic [PCW-1:0] nxt_p;
   logic [PCW-1:0] act_p;
   logic [PCW-1:0] p_use;
   logic           a_go;
   logic [PCW-1:0] rl_val;

   assign term      = pre_tc & b_last;
   assign p_use     = term ? nxt_p : act_p;
   assign a_go      = term ? (nxt_a != '0) : (a_dec != '0);
   assign rl_val    = a_go ? p_use : p_use - 1'b1;
   assign div_pulse = term;
   assign mod_ctl   = (a_cnt != '0);

   dmp_cfg_guard #(
      .AW(AW), .BW(BW), .RST_A(RST_A), .RST_B(RST_B), .RST_SEL(RST_SEL)
   ) u_guard (
      .clk(clk), .rst_n(rst_n),
      .a_in(swallow_in), .b_in(main_in), .sel_in(ps_sel), .take(term),
      .nxt_a(nxt_a), .nxt_b(nxt_b), .nxt_p(nxt_p), .act_p(act_p),
      .cfg_err(cfg_err)
   );

   dmp_prescaler #(
      .PCW(PCW), .RST_VAL(RST_PC)
   ) u_pre (
      .clk(clk), .rst_n(rst_n), .rl_val(rl_val), .tc(pre_tc)
   );

   dmp_ab_counters #(
      .AW(AW), .BW(BW), .RST_A(RST_A), .RST_B(RST_B)
   ) u_ab (
      .clk(clk), .rst_n(rst_n), .pre_tc(pre_tc), .load(term),
      .ld_a(nxt_a), .ld_b(nxt_b),
      .a_cnt(a_cnt), .a_dec(a_dec), .b_last(b_last)
   );
endmodule

// File: rtl/dmp_divider_chk.sv
module dmp_divider_chk #(
   parameter int AW = 6,
   parameter int BW = 13
) (
   input logic          clk,
   input logic          rst_n,
   input logic [AW-1:0] swallow_in,
   input logic [BW-1:0] main_in,
   input logic [1:0]    ps_sel,
   input logic          div_pulse,
   input logic          mod_ctl,
   input logic          cfg_err
);
   AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      div_pulse |=> !div_pulse);                                          // R4
   AST_MOD_NO_REARM: assert property (@(posedge clk) disable iff (!rst_n)
      (!mod_ctl && !div_pulse) |=> !mod_ctl);                             // R3
   AST_ERR_B_BELOW_A: assert property (@(posedge clk) disable iff (!rst_n)
      (main_in < BW'(swallow_in)) |=> cfg_err);                           // R8
   AST_ERR_BAD_SEL: assert property (@(posedge clk) disable iff (!rst_n)
      (ps_sel == 2'd3) |=> cfg_err);                                      // R8
   AST_ERR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (ps_sel != 2'd3 && main_in >= BW'(swallow_in) && main_in != '0
       && swallow_in < AW'(8)) |=> !cfg_err);                             // R9
endmodule

bind dmp_divider dmp_divider_chk #(.AW(AW), .BW(BW)) u_chk (
   .clk(clk), .rst_n(rst_n), .swallow_in(swallow_in), .main_in(main_in),
   .ps_sel(ps_sel), .div_pulse(div_pulse), .mod_ctl(mod_ctl),
   .cfg_err(cfg_err)
);

// File: tb/dmp_divider_test.sv
module dmp_divider_test;
   localparam int AW = 6;
   localparam int BW = 13;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [AW-1:0] a_in = '0;
   logic [BW-1:0] b_in = BW'(1);
   logic [1:0]    sel = 2'd0;
   logic          div_pulse, mod_ctl, cfg_err;
   int            n_run = 0;
   int            n_fail = 0;

   always #10 clk = ~clk;

   dmp_divider uut (
      .clk(clk), .rst_n(rst_n), .swallow_in(a_in), .main_in(b_in),
      .ps_sel(sel), .div_pulse(div_pulse), .mod_ctl(mod_ctl),
      .cfg_err(cfg_err)
   );

   task automatic chk(input string tag, input int act, input int exp);
      n_run++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   function automatic int pval(input logic [1:0] s);
      return (s == 2'd0) ? 8 : (s == 2'd1) ? 16 : 32;
   endfunction

   // Counts cycles (and mod_ctl-high cycles) up to and including the next pulse
   task automatic run_frame(output int len, output int hi);
      len = 0;
      hi  = 0;
      do begin
         @(negedge clk);
         len++;
         if (mod_ctl) hi++;
      end while (!div_pulse);
   endtask

   task automatic t_reset();
      int cnt, hi;
      repeat (3) @(negedge clk);
      chk("R1 pulse in reset", int'(div_pulse), 0);
      chk("R1 mod in reset", int'(mod_ctl), 0);
      chk("R1 err in reset", int'(cfg_err), 0);
      rst_n = 1'b1;
      run_frame(cnt, hi);
      chk("R1 first pulse cycle", cnt, 7);
      chk("R1 mod after reset", hi, 0);
      run_frame(cnt, hi);
      chk("R4 single-cycle pulse spacing", cnt, 8);
   endtask

   // Called at a pulse cycle: the new setting governs the frame that follows
   task automatic t_period(input int a, input int b, input logic [1:0] s,
                           input string tag);
      int len, hi;
      a_in = AW'(a);
      b_in = BW'(b);
      sel  = s;
      run_frame(len, hi);
      chk({tag, " period"}, len, b * pval(s) + a);
      chk({tag, " mod_ctl cycles"}, hi, a * (pval(s) + 1));
   endtask

   task automatic t_midframe();
      int len, hi;
      t_period(3, 10, 2'd0, "R7 setup");
      repeat (20) @(negedge clk);
      a_in = AW'(1);
      b_in = BW'(2);
      sel  = 2'd0;
      run_frame(len, hi);
      chk("R7 running frame kept", len, 83 - 20);
      run_frame(len, hi);
      chk("R7 new frame", len, 17);
   endtask

   // Starts with the legal setting A=1, B=2, P=8 active (17 cycles)
   task automatic t_bad(input int a, input int b, input logic [1:0] s,
                        input string tag);
      int len, hi;
      a_in = AW'(a);
      b_in = BW'(b);
      sel  = s;
      @(negedge clk);
      chk({"R8 err ", tag}, int'(cfg_err), 1);
      run_frame(len, hi);
      run_frame(len, hi);
      chk({"R8 kept period ", tag}, len, 17);
      a_in = AW'(1);
      b_in = BW'(2);
      sel  = 2'd0;
      @(negedge clk);
      chk({"R9 err cleared ", tag}, int'(cfg_err), 0);
      run_frame(len, hi);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      t_reset();
      t_period(5, 20, 2'd1, "R2 P=16");
      t_period(3, 4, 2'd0, "R2 P=8");
      t_period(7, 7, 2'd0, "R5 B=A P=8");
      t_period(31, 31, 2'd2, "R5 B=A P=32");
      t_period(0, 31, 2'd2, "R11 min ratio R6");
      t_period(0, 1, 2'd0, "R6 A=0");
      t_period(9, 40, 2'd2, "R2 R3 P=32");
      t_midframe();
      t_bad(1, 2, 2'd3, "sel3");
      t_bad(8, 9, 2'd0, "A>=P");
      t_bad(5, 3, 2'd1, "B<A");
      t_bad(0, 0, 2'd0, "B=0");
      t_period(7, 8191, 2'd0, "R10 max B");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule